// File: doc/BRIEF.md
# Tagged Multi-Channel Receive Aggregator

This block gathers bytes from several independent serial receive buffers into one shared byte store that an external controller empties. Each receive buffer presents a byte, a read strobe and three fill flags: not empty, at least half full, and completely full. An arbiter serves one channel at a time and empties it in a single burst. It places one identifier byte at the head of each burst, so the controller can tell which channel the following bytes came from while paying the tag cost once per burst rather than once per byte.

A burst starts when a channel reaches half full. It also starts when a channel has held a few bytes below that level for a programmable number of clocks, so short messages are not held back. When several channels are waiting they are served in rotation. While the controller holds its busy input the block writes nothing into the store. A byte already read from a channel is kept in a holding register until the store accepts it. A per-channel sticky flag records that a buffer was seen full before it was being served.

Top module: `rx_tag_aggregator`

## Requirements
- R1: After reset the store is empty (`ctl_valid` 0, `store_count` 0), `store_full` is 0, no channel strobe is active and every overflow flag is 0.
- R2: A channel whose half-full flag is high starts a burst. The burst writes the identifier byte `8'hF0 | index` (0xF0 to 0xF3 for channels 0 to 3), then that channel's bytes in arrival order, and it continues until the channel's not-empty flag is low.
- R3: While `ctl_busy` is high `store_count` never rises, because no byte is written. Draining resumes without loss once `ctl_busy` falls.
- R4: Every channel read takes two cycles, strobe then capture, so a strobe is never active in two consecutive cycles.
- R5: At most one channel strobe is active in any cycle, and only for a channel whose not-empty flag is high.
- R6: A channel that has data but stays below half full for `IDLE_LIMIT` consecutive clocks starts a burst of its own.
- R7: When several channels request together, they are served in rotation beginning with the index after the channel picked last.
- R8: The store holds at most `STORE_DEPTH` bytes (36 by default). When it is full, draining stalls and no byte is lost or duplicated.
- R9: `store_full` is high exactly when `store_count` is at least `FULL_MARK` (32 by default).
- R10: `ovf_flags[i]` is set when channel i's full flag is high while that channel is not the one being served. It stays set until reset.
- R11: The store is a show-ahead FIFO. `ctl_data` shows the oldest byte, and a `ctl_rd` pulse while the store is empty has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ch_data | input | NCH*DW | Byte from each channel buffer, channel i at bits [i*DW +: DW], valid the cycle after its strobe |
| ch_present | input | NCH | Channel buffer not empty |
| ch_half | input | NCH | Channel buffer at least half full |
| ch_full | input | NCH | Channel buffer full |
| ch_rd | output | NCH | One-cycle read strobe for each channel buffer |
| ctl_busy | input | 1 | Controller is reading; writes into the store are frozen |
| ctl_rd | input | 1 | Controller pops the oldest byte of the store |
| ctl_data | output | DW | Oldest byte in the store |
| ctl_valid | output | 1 | Store holds at least one byte |
| store_full | output | 1 | Store occupancy at or above `FULL_MARK` |
| store_count | output | CW | Number of bytes in the store |
| ovf_flags | output | NCH | Sticky flag for each channel: buffer was full before it was served |

## Verification
The assertions assume the channel buffers behave as registered FIFOs. A strobe pops exactly one byte, that byte appears on `ch_data` in the following cycle, and the not-empty flag is true whenever a byte is stored. The bench satisfies this with a behavioural 16-entry FIFO per channel, which pops on `ch_rd` and ignores pushes when full. The assertions also assume the controller only pops while it holds `ctl_busy` high. The bench raises busy a few cycles before its first pop and releases it only after its last pop.

// File: rtl/rx_tag_aggregator.sv
module rx_tag_aggregator #(
  parameter int NCH = 4,
  parameter int DW = 8,
  parameter int RX_DEPTH = 16,
  parameter int STORE_DEPTH = NCH * (RX_DEPTH / 2) + 4,
  parameter int FULL_MARK = STORE_DEPTH - 4,
  parameter int IDLE_LIMIT = 2000,
  parameter logic [DW-1:0] TAG_BASE = 'hF0,
  localparam int CW = $clog2(STORE_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH*DW-1:0] ch_data,
  input  logic [NCH-1:0]    ch_present,
  input  logic [NCH-1:0]    ch_half,
  input  logic [NCH-1:0]    ch_full,
  output logic [NCH-1:0]    ch_rd,
  input  logic              ctl_busy,
  input  logic              ctl_rd,
  output logic [DW-1:0]     ctl_data,
  output logic              ctl_valid,
  output logic              store_full,
  output logic [CW-1:0]     store_count,
  output logic [NCH-1:0]    ovf_flags
);
  localparam int IW = $clog2(NCH);
  localparam int AW = $clog2(STORE_DEPTH);
  localparam int TW = $clog2(IDLE_LIMIT + 1);

  typedef enum logic [2:0] {S_IDLE, S_TAG, S_STROBE, S_CAPTURE, S_HOLD} st_t;

  st_t            st;
  logic [IW-1:0]  cur, last, pick;
  logic           found;
  logic [DW-1:0]  hold, wr_byte, cur_data;
  logic           wr_en, rd_en, can_wr;
  logic [DW-1:0]  mem [STORE_DEPTH];
  logic [AW-1:0]  wptr, rptr;
  logic [CW-1:0]  cnt;
  logic [TW-1:0]  idle_t [NCH];
  logic [NCH-1:0] req;

  assign can_wr      = !ctl_busy && (cnt < CW'(STORE_DEPTH));
  assign rd_en       = ctl_rd && (cnt != '0);
  assign cur_data    = ch_data[cur*DW +: DW];
  assign ctl_data    = mem[rptr];
  assign ctl_valid   = (cnt != '0);
  assign store_full  = (cnt >= CW'(FULL_MARK));
  assign store_count = cnt;

  always_comb begin
    for (int i = 0; i < NCH; i++)
      req[i] = ch_half[i] || (ch_present[i] && idle_t[i] == TW'(IDLE_LIMIT));
  end

  always_comb begin
    found = 1'b0;
    pick  = last;
    for (int k = 1; k <= NCH; k++) begin
      int j;
      j = (int'(last) + k) % NCH;
      if (!found && req[j]) begin
        found = 1'b1;
        pick  = IW'(j);
      end
    end
  end

  always_comb begin
    wr_en   = 1'b0;
    wr_byte = hold;
    case (st)
      S_TAG:     begin wr_en = can_wr; wr_byte = TAG_BASE | DW'(cur); end
      S_CAPTURE: begin wr_en = can_wr; wr_byte = cur_data; end
      S_HOLD:    wr_en = can_wr;
      default:   ;
    endcase
  end

  always_comb begin
    ch_rd = '0;
    if (st == S_STROBE && ch_present[cur] && can_wr) ch_rd[cur] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      cur  <= '0;
      last <= IW'(NCH - 1);
      hold <= '0;
    end else begin
      case (st)
        S_IDLE: if (found) begin
          cur  <= pick;
          last <= pick;
          st   <= S_TAG;
        end
        S_TAG: if (can_wr) st <= S_STROBE;
        S_STROBE:
          if (!ch_present[cur]) st <= S_IDLE;
          else if (can_wr)      st <= S_CAPTURE;
        S_CAPTURE: begin
          hold <= cur_data;
          st   <= can_wr ? S_STROBE : S_HOLD;
        end
        S_HOLD: if (can_wr) st <= S_STROBE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NCH; i++) begin
      if (!rst_n) begin
        idle_t[i]    <= '0;
        ovf_flags[i] <= 1'b0;
      end else begin
        if (!ch_present[i] || (st != S_IDLE && cur == IW'(i)))
          idle_t[i] <= '0;
        else if (idle_t[i] != TW'(IDLE_LIMIT))
          idle_t[i] <= idle_t[i] + 1'b1;
        if (ch_full[i] && !(st != S_IDLE && cur == IW'(i)))
          ovf_flags[i] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wptr] <= wr_byte;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (wr_en) wptr <= (wptr == AW'(STORE_DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (rd_en) rptr <= (rptr == AW'(STORE_DEPTH - 1)) ? '0 : rptr + 1'b1;
      case ({wr_en, rd_en})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/rx_tag_aggregator_chk.sv
module rx_tag_aggregator_chk #(
  parameter int NCH = 4,
  parameter int CW = 6,
  parameter int STORE_DEPTH = 36
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] ch_rd,
  input logic [NCH-1:0] ch_present,
  input logic [NCH-1:0] ovf_flags,
  input logic           ctl_busy,
  input logic [CW-1:0]  store_count
);
  assert_one_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ch_rd));
  assert_strobe_present_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_rd & ~ch_present) == '0);
  assert_two_cycle_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_rd != '0) |=> (ch_rd == '0));
  assert_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_busy |=> (store_count <= $past(store_count)));
  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    store_count <= CW'(STORE_DEPTH));
  assert_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((ovf_flags & $past(ovf_flags)) == $past(ovf_flags)));
endmodule

bind rx_tag_aggregator rx_tag_aggregator_chk #(
  .NCH(NCH), .CW(CW), .STORE_DEPTH(STORE_DEPTH)
) chk_i (
  .clk(clk), .rst_n(rst_n), .ch_rd(ch_rd), .ch_present(ch_present),
  .ovf_flags(ovf_flags), .ctl_busy(ctl_busy), .store_count(store_count)
);

// File: tb/rx_tag_aggregator_tb_top.sv
module rx_tag_aggregator_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;
  localparam int DW = 8;
  localparam int IDLE_LIM = 40;
  localparam int SD = 36;
  localparam int CW = $clog2(SD + 1);
  localparam int NVEC = 6;
  // {channel[1:0], count[5:0], base[7:0]}
  localparam logic [15:0] VEC [NVEC] = '{
    {2'd0, 6'd8,  8'h10}, {2'd1, 6'd3,  8'h20}, {2'd2, 6'd16, 8'h30},
    {2'd3, 6'd12, 8'h50}, {2'd0, 6'd1,  8'h70}, {2'd2, 6'd7,  8'h90}};

  logic clk = 0, rst_n = 0;
  logic [NCH*DW-1:0] ch_data;
  logic [NCH-1:0] ch_present, ch_half, ch_full, ch_rd, ovf_flags;
  logic ctl_busy = 0, ctl_rd = 0, ctl_valid, store_full;
  logic [DW-1:0] ctl_data;
  logic [CW-1:0] store_count;

  int checks = 0, errors = 0, r4_bad = 0, r5_bad = 0;
  logic [DW-1:0] exp_q [$];

  logic [NCH-1:0] push_en = '0;
  logic [DW-1:0]  push_val [NCH];
  logic [DW-1:0]  fmem [NCH][16];
  logic [3:0]     fhead [NCH], ftail [NCH];
  logic [4:0]     fcnt [NCH];
  logic [DW-1:0]  fdout [NCH];
  logic [NCH-1:0] prev_rd = '0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  rx_tag_aggregator #(.NCH(NCH), .DW(DW), .RX_DEPTH(16), .IDLE_LIMIT(IDLE_LIM)) dut_i (
    .clk(clk), .rst_n(rst_n), .ch_data(ch_data), .ch_present(ch_present),
    .ch_half(ch_half), .ch_full(ch_full), .ch_rd(ch_rd), .ctl_busy(ctl_busy),
    .ctl_rd(ctl_rd), .ctl_data(ctl_data), .ctl_valid(ctl_valid),
    .store_full(store_full), .store_count(store_count), .ovf_flags(ovf_flags));

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      ch_data[c*DW +: DW] = fdout[c];
      ch_present[c] = (fcnt[c] != 0);
      ch_half[c]    = (fcnt[c] >= 8);
      ch_full[c]    = (fcnt[c] == 16);
    end
  end

  always_ff @(posedge clk) begin
    for (int c = 0; c < NCH; c++) begin
      if (!rst_n) begin
        fhead[c] <= '0; ftail[c] <= '0; fcnt[c] <= '0; fdout[c] <= '0;
      end else begin
        logic pop, psh;
        pop = ch_rd[c] && fcnt[c] != 0;
        psh = push_en[c] && fcnt[c] != 16;
        if (pop) begin
          fdout[c] <= fmem[c][fhead[c]];
          fhead[c] <= fhead[c] + 1'b1;
        end
        if (psh) begin
          fmem[c][ftail[c]] <= push_val[c];
          ftail[c] <= ftail[c] + 1'b1;
        end
        fcnt[c] <= fcnt[c] + 5'(psh) - 5'(pop);
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_rd != '0 && ch_rd != '0) r4_bad++;
      if ((ch_rd & ~ch_present) != '0 || $countones(ch_rd) > 1) r5_bad++;
      prev_rd <= ch_rd;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push_set(input logic [NCH-1:0] mask, input int n, input logic [7:0] base);
    for (int k = 0; k < n; k++) begin
      for (int c = 0; c < NCH; c++) begin
        push_en[c] = mask[c];
        push_val[c] = base + 8'(c * 32 + k);
      end
      @(negedge clk);
    end
    push_en = '0;
  endtask

  task automatic expect_burst(input int c, input int n, input logic [7:0] base);
    exp_q.push_back(8'hF0 | 8'(c));
    for (int k = 0; k < n; k++) exp_q.push_back(base + 8'(c * 32 + k));
  endtask

  task automatic drain(input string req);
    int guard = 0;
    while (exp_q.size() > 0 && guard < 40) begin
      guard++;
      ctl_busy = 1;
      repeat (3) @(negedge clk);
      while (ctl_valid && exp_q.size() > 0) begin
        chk(ctl_data == exp_q[0], req, ctl_data, exp_q[0]);
        void'(exp_q.pop_front());
        ctl_rd = 1;
        @(negedge clk);
        ctl_rd = 0;
      end
      ctl_busy = 0;
      repeat (200) @(negedge clk);
    end
    chk(exp_q.size() == 0, {req, " missing bytes"}, exp_q.size(), 0);
    exp_q.delete();
    chk(!ctl_valid, {req, " extra bytes"}, store_count, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int c = 0; c < NCH; c++) push_val[c] = '0;
    repeat (3) @(negedge clk);
    chk(!ctl_valid && store_count == 0 && ch_rd == '0, "R1 empty in reset", store_count, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!ctl_valid && store_count == 0, "R1 store empty", store_count, 0);
    chk(!store_full && ovf_flags == '0 && ch_rd == '0, "R1 flags clear", ovf_flags, 0);

    // R11: pop on empty store is ignored
    ctl_busy = 1; ctl_rd = 1;
    @(negedge clk);
    ctl_rd = 0; ctl_busy = 0;
    chk(store_count == 0 && !ctl_valid, "R11 empty pop", store_count, 0);

    // vector table: R2 (half-full bursts) and R6 (timeout bursts)
    for (int v = 0; v < NVEC; v++) begin
      int c, n;
      c = int'(VEC[v][15:14]);
      n = int'(VEC[v][13:8]);
      push_set(NCH'(1) << c, n, VEC[v][7:0]);
      expect_burst(c, n, VEC[v][7:0]);
      repeat (150) @(negedge clk);
      drain(n >= 8 ? "R2 burst order" : "R6 timeout burst");
    end
    chk(ovf_flags == '0, "R10 no overflow", ovf_flags, 0);

    // R6: short message waits for the timeout
    push_set(4'b1000, 3, 8'hA0);
    repeat (IDLE_LIM - 15) @(negedge clk);
    chk(store_count == 0, "R6 before timeout", store_count, 0);
    repeat (60) @(negedge clk);
    chk(store_count == 4, "R6 after timeout", store_count, 4);
    expect_burst(3, 3, 8'hA0);
    drain("R6 timeout data");

    // R3: frozen while controller busy
    ctl_busy = 1;
    push_set(4'b0100, 10, 8'h05);
    repeat (100) @(negedge clk);
    chk(store_count == 0, "R3 no write while busy", store_count, 0);
    chk(fcnt[2] == 10, "R3 channel untouched", fcnt[2], 10);
    ctl_busy = 0;
    repeat (200) @(negedge clk);
    expect_burst(2, 10, 8'h05);
    drain("R3 resumed data");

    // R7: round robin after channel 2 -> 3, 0, 1
    ctl_busy = 1;
    push_set(4'b1011, 8, 8'h08);
    ctl_busy = 0;
    repeat (300) @(negedge clk);
    chk(store_count == 27, "R7 all bursts stored", store_count, 27);
    chk(!store_full, "R9 below mark", store_full, 0);
    expect_burst(3, 8, 8'h08);
    expect_burst(0, 8, 8'h08);
    expect_burst(1, 8, 8'h08);
    drain("R7 rotation order");

    // R8/R9/R10: overfill the store, order 2, 0, 1
    ctl_busy = 1;
    push_set(4'b0111, 16, 8'h01);
    repeat (5) @(negedge clk);
    chk(ovf_flags == 4'b0011, "R10 full before service", ovf_flags, 4'b0011);
    ctl_busy = 0;
    repeat (400) @(negedge clk);
    chk(store_count == SD, "R8 store capped", store_count, SD);
    chk(store_full, "R9 mark reached", store_full, 1);
    chk(ovf_flags == 4'b0011, "R10 sticky", ovf_flags, 4'b0011);
    expect_burst(2, 16, 8'h01);
    expect_burst(0, 16, 8'h01);
    expect_burst(1, 16, 8'h01);
    drain("R8 stall without loss");
    chk(!store_full, "R9 cleared", store_full, 0);

    chk(r4_bad == 0, "R4 two-cycle read", r4_bad, 0);
    chk(r5_bad == 0, "R5 single valid strobe", r5_bad, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule